// File: doc/BRIEF.md
# Jitter Self-Test Sequencing Controller

This controller runs one measurement of a charge-pump loop's jitter, or one calibration of its resolution. A pulse on the start input begins the sequence. The controller first lets the loop track the reference clock through the normal phase detector. It then hands the shared loop filter over to a one-shot test detector, which captures a single phase difference while the loop is open. Last, it opens a counting window in which the divider edges are counted. The controller never looks at any analog quantity. It only produces the enables and the mux select that steer the shared hardware.

All state changes happen on the falling edge of the reference clock. Because of this, every enable is settled before the next rising reference and feedback edges reach the detectors. The three step lengths, counted in reference cycles, and the measurement mode are captured when the sequence starts. In calibrate mode, the mux select routes the divider's one-period pulse to the charge pump in place of the test detector output.

Top module: `jbist_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, loop_pd_en_o is 1 and test_pd_en_o, cnt_en_o, cal_sel_o and done_o are 0.
- R2: A start_i sampled high in idle begins the tracking step. For max(track_len_i,1) cycles loop_pd_en_o stays 1 and the other outputs stay 0. loop_pd_en_o and test_pd_en_o are never high together.
- R3: The phase-detection step follows tracking and lasts max(detect_len_i,1) cycles. During it loop_pd_en_o and cnt_en_o are 0, so the loop is open.
- R4: test_pd_en_o is 1 for exactly one cycle, the first cycle of the phase-detection step, and is 0 at all other times.
- R5: The counting step follows at once. cnt_en_o is 1 for exactly max(count_len_i,1) consecutive cycles, with loop_pd_en_o held at 0.
- R6: When cal_mode_i (1 = calibrate, 0 = jitter test) was 1 at start, cal_sel_o is 1 throughout the detection and counting steps and 0 at all other times. In test mode cal_sel_o stays 0.
- R7: After counting, done_o is 1 for one cycle. In that same cycle loop_pd_en_o is 1 again, and the controller then returns to idle.
- R8: While a sequence runs, start_i is ignored. Changes to the length inputs or to cal_mode_i after start do not affect the running sequence.
- R9: A step length of 0 is treated as 1 cycle.
- R10: Outputs change only on the falling edge of ref_clk_i. A rising edge never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; the logic acts on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one sequence (honoured only in idle) |
| cal_mode_i | input | 1 | 1 = calibrate, 0 = jitter test |
| track_len_i | input | 16 | Tracking step length in cycles |
| detect_len_i | input | 16 | Phase-detection step length in cycles |
| count_len_i | input | 16 | Counting window length in cycles |
| loop_pd_en_o | output | 1 | Enable of the normal loop phase detector |
| test_pd_en_o | output | 1 | One-shot enable of the test phase detector |
| cnt_en_o | output | 1 | Divider-edge counter enable |
| cal_sel_o | output | 1 | Charge-pump mux select: 1 = divider pulse |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The hardest case to reach is a start request, or a change to a length or the mode, that arrives while a sequence is already running. Each of these must leave the running sequence exactly as it was. The bench covers this in random runs: at every rising edge it re-randomizes start_i, the lengths and the mode. It stops doing so one cycle before done, so that the next run is not triggered by accident. Directed runs with all lengths set to zero cover the single-cycle corners, where the one-shot cycle and the last detection cycle coincide.

// File: rtl/jbist_pkg.sv
package jbist_pkg;
  parameter int unsigned LEN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TRACK  = 3'd1,
    ST_DETECT = 3'd2,
    ST_COUNT  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;

  // cycles to preload: a length of 0 behaves as 1
  function automatic logic [LEN_W-1:0] len_to_load(input logic [LEN_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction
endpackage

// File: rtl/jbist_step_timer.sv
module jbist_step_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/jbist_seq_fsm.sv
module jbist_seq_fsm
  import jbist_pkg::*;
#(
  parameter int unsigned W = LEN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cal_mode_i,
  input  logic [W-1:0] track_len_i,
  input  logic [W-1:0] detect_len_i,
  input  logic [W-1:0] count_len_i,
  input  logic         step_end_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output seq_state_e   state_o,
  output logic         arm_o,
  output logic         mode_o
);
  seq_state_e   state_q, state_d;
  logic [W-1:0] det_len_q, cnt_len_q;
  logic         mode_q, arm_q;
  logic         accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_TRACK;
        tmr_load_o = 1'b1;
        tmr_val_o  = len_to_load(track_len_i);
      end
      ST_TRACK: if (step_end_i) begin
        state_d    = ST_DETECT;
        tmr_load_o = 1'b1;
        tmr_val_o  = len_to_load(det_len_q);
      end
      ST_DETECT: if (step_end_i) begin
        state_d    = ST_COUNT;
        tmr_load_o = 1'b1;
        tmr_val_o  = len_to_load(cnt_len_q);
      end
      ST_COUNT: if (step_end_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      det_len_q <= '0;
      cnt_len_q <= '0;
      mode_q    <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      // one-shot: only the cycle entering detection
      arm_q   <= (state_q == ST_TRACK) && (state_d == ST_DETECT);
      if (accept) begin
        det_len_q <= detect_len_i;
        cnt_len_q <= count_len_i;
        mode_q    <= cal_mode_i;
      end
    end
  end

  assign state_o = state_q;
  assign arm_o   = arm_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/jbist_seq_decode.sv
module jbist_seq_decode
  import jbist_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       arm_i,
  input  logic       mode_i,
  output logic       loop_pd_en_o,
  output logic       test_pd_en_o,
  output logic       cnt_en_o,
  output logic       cal_sel_o,
  output logic       done_o
);
  logic loop_open;

  assign loop_open    = (state_i == ST_DETECT) || (state_i == ST_COUNT);
  assign loop_pd_en_o = !loop_open;
  assign test_pd_en_o = arm_i && (state_i == ST_DETECT);
  assign cnt_en_o     = (state_i == ST_COUNT);
  assign cal_sel_o    = mode_i && loop_open;
  assign done_o       = (state_i == ST_DONE);
endmodule

// File: rtl/jbist_seq_ctrl.sv
module jbist_seq_ctrl
  import jbist_pkg::*;
#(
  parameter int unsigned W = LEN_W
) (
  input  logic         ref_clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cal_mode_i,
  input  logic [W-1:0] track_len_i,
  input  logic [W-1:0] detect_len_i,
  input  logic [W-1:0] count_len_i,
  output logic         loop_pd_en_o,
  output logic         test_pd_en_o,
  output logic         cnt_en_o,
  output logic         cal_sel_o,
  output logic         done_o
);
  logic         tmr_load, tmr_zero, arm, mode;
  logic [W-1:0] tmr_val;
  seq_state_e   state;

  jbist_step_timer #(.W(W)) u_timer (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  jbist_seq_fsm #(.W(W)) u_fsm (
    .clk_i        (ref_clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cal_mode_i   (cal_mode_i),
    .track_len_i  (track_len_i),
    .detect_len_i (detect_len_i),
    .count_len_i  (count_len_i),
    .step_end_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .state_o      (state),
    .arm_o        (arm),
    .mode_o       (mode)
  );

  jbist_seq_decode u_dec (
    .state_i      (state),
    .arm_i        (arm),
    .mode_i       (mode),
    .loop_pd_en_o (loop_pd_en_o),
    .test_pd_en_o (test_pd_en_o),
    .cnt_en_o     (cnt_en_o),
    .cal_sel_o    (cal_sel_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/jbist_seq_ctrl_chk.sv
module jbist_seq_ctrl_chk (
  input logic ref_clk_i,
  input logic rst_ni,
  input logic loop_pd_en_o,
  input logic test_pd_en_o,
  input logic cnt_en_o,
  input logic cal_sel_o,
  input logic done_o
);
  p_excl_en_r2: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    !(loop_pd_en_o && test_pd_en_o));

  p_open_detect_r3: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    $rose(test_pd_en_o) |-> $past(loop_pd_en_o));

  p_one_shot_r4: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    test_pd_en_o |=> !test_pd_en_o);

  p_count_open_r5: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    cnt_en_o |-> !loop_pd_en_o && !test_pd_en_o);

  p_sel_open_r6: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    cal_sel_o |-> !loop_pd_en_o);

  p_done_pulse_r7: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    done_o |-> loop_pd_en_o && !cal_sel_o && !cnt_en_o);

  p_done_once_r7: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_count_r5: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    $fell(cnt_en_o) |-> done_o);
endmodule

bind jbist_seq_ctrl jbist_seq_ctrl_chk u_chk (
  .ref_clk_i    (ref_clk_i),
  .rst_ni       (rst_ni),
  .loop_pd_en_o (loop_pd_en_o),
  .test_pd_en_o (test_pd_en_o),
  .cnt_en_o     (cnt_en_o),
  .cal_sel_o    (cal_sel_o),
  .done_o       (done_o)
);

// File: tb/jbist_seq_ctrl_tb.sv
module jbist_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cal = 1'b0;
  logic [15:0] tl = '0, dl = '0, cl = '0;
  logic        loop_en, test_en, cnt_en, sel, done;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  jbist_seq_ctrl u_dut (
    .ref_clk_i(clk), .rst_ni(rst_n), .start_i(start), .cal_mode_i(cal),
    .track_len_i(tl), .detect_len_i(dl), .count_len_i(cl),
    .loop_pd_en_o(loop_en), .test_pd_en_o(test_en), .cnt_en_o(cnt_en),
    .cal_sel_o(sel), .done_o(done)
  );

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected {loop, test, cnt, sel, done} for cycle i after acceptance
  function automatic logic [4:0] exp_out(input int i, input int t, input int d,
                                         input int c, input logic m);
    if (i <= t)             return 5'b10000;
    if (i == t + 1)         return {3'b010, m, 1'b0};
    if (i <= t + d)         return {3'b000, m, 1'b0};
    if (i <= t + d + c)     return {3'b001, m, 1'b0};
    if (i == t + d + c + 1) return 5'b10001;
    return 5'b10000;
  endfunction

  function automatic string tag_of(input int i, input int t, input int d, input int c);
    if (i <= t)             return "R2";
    if (i == t + 1)         return "R4";
    if (i <= t + d)         return "R3";
    if (i <= t + d + c)     return "R5";
    if (i == t + d + c + 1) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {loop_en, test_en, cnt_en, sel, done};
  endfunction

  task automatic run_seq(input int t_raw, input int d_raw, input int c_raw,
                         input logic m, input bit disturb, input string extra);
    int t = clamp1(t_raw), d = clamp1(d_raw), c = clamp1(c_raw);
    int total = t + d + c + 1;
    @(posedge clk);
    tl = 16'(t_raw); dl = 16'(d_raw); cl = 16'(c_raw); cal = m; start = 1'b1;
    #1 check("R10", outs(), 5'b10000); // rising edge causes no change
    for (int i = 1; i <= total + 2; i++) begin
      @(posedge clk);
      begin
        logic [4:0] e = exp_out(i, t, d, c, m);
        string tg = tag_of(i, t, d, c);
        check(extra.len() > 0 ? extra : tg, outs(), e);
        if (m && (e[1] !== 1'b0) && (outs() !== e)) check("R6", outs(), e);
      end
      if (disturb && i < total) begin
        start = 1'($urandom_range(0, 1));
        tl = 16'($urandom_range(0, 30)); dl = 16'($urandom_range(0, 30));
        cl = 16'($urandom_range(0, 30)); cal = 1'($urandom_range(0, 1));
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(posedge clk); @(posedge clk);
    check("R1", outs(), 5'b10000);
    @(posedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    check("R1", outs(), 5'b10000);

    run_seq(3, 4, 5, 1'b0, 1'b0, "");
    run_seq(2, 3, 4, 1'b1, 1'b0, "R6");
    run_seq(0, 0, 0, 1'b0, 1'b0, "R9");
    run_seq(0, 0, 0, 1'b1, 1'b0, "R9");
    run_seq(1, 1, 1, 1'b1, 1'b0, "");
    run_seq(5, 2, 7, 1'b1, 1'b1, "R8");
    run_seq(0, 6, 0, 1'b0, 1'b1, "R8");
    for (int k = 0; k < 12; k++)
      run_seq($urandom_range(0, 25), $urandom_range(0, 25), $urandom_range(0, 40),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "");
    run_seq(600, 40, 2000, 1'b1, 1'b0, "");

    // reset mid-sequence
    @(posedge clk);
    tl = 16'd10; dl = 16'd10; cl = 16'd10; cal = 1'b1; start = 1'b1;
    repeat (14) @(posedge clk);
    start = 1'b0; rst_n = 1'b0;
    #1 check("R1", outs(), 5'b10000);
    @(posedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check("R1", outs(), 5'b10000);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule